// File: doc/BRIEF.md
# Lane Load Coalescer

The block takes one load batch from a group of 32 lanes. Each lane offers an active flag and the byte address of a 4-byte word. Memory is fetched in 128-byte lines, so lanes whose words lie in the same line can share one fetch. The block merges those lanes and sends one line request per distinct line to a downstream memory port.

Each request carries the line address and a lane mask. The data-return logic uses the mask to hand the fetched line back to the lanes that asked for it. Requests leave in a fixed order under a valid/ready handshake. When the last request of a batch has been taken, a one-cycle done pulse reports how many requests the batch needed. That number is between 1 and 32 for a batch with at least one active lane, and 0 for an empty batch.

Top module: `lane_coalescer`

## Requirements
- R1: `req_line` is the byte address of the leading lane with its low 7 bits forced to zero.
- R2: A batch in which all 32 lanes are active and read consecutive 4-byte words starting on a 128-byte boundary produces exactly one request, with mask `32'hFFFFFFFF`.
- R3: A batch in which every active lane falls in a different line produces one request per active lane. With all 32 lanes active, that is 32 requests.
- R4: Requests are issued in order of the lowest-numbered active lane that has not yet been served. Each mask holds every remaining active lane whose line address equals that lane's line address, where bit i of the mask stands for lane i.
- R5: A lane whose `lane_active` bit is 0 never appears in a mask and causes no request.
- R6: A batch with no active lanes issues no request. `done` rises in the cycle after acceptance with `done_count` equal to 0.
- R7: `batch_ready` is 1 after reset and while no request is pending. It falls after a batch with active lanes is accepted and rises again in the cycle after the final handshake. While it is 0, `batch_valid` is ignored.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_line` and `req_mask` hold their values into the next cycle.
- R9: `done` is a single-cycle pulse in the cycle after the final handshake of a batch. `done_count` then equals the number of requests issued for that batch. `done` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| batch_valid | input | 1 | A batch is offered |
| batch_ready | output | 1 | The block can accept a batch |
| lane_active | input | 32 | Per-lane active flag; bit i is lane i |
| lane_addr | input | 1024 | Per-lane byte address; lane i in bits [32*i+31:32*i] |
| req_valid | output | 1 | A line request is presented |
| req_ready | input | 1 | The downstream port takes the request |
| req_line | output | 32 | Line-aligned byte address of the request |
| req_mask | output | 32 | Lanes served by the request |
| done | output | 1 | One-cycle pulse at the end of a batch |
| done_count | output | 6 | Number of requests issued for the finished batch |

## Verification
The ordering rule is the hardest behaviour to exercise. It only shows up when the lane holding the lowest unserved index belongs to a line that later lanes also use, while other lines interleave between them. Linear strides never create that situation. The stimulus therefore includes address patterns where lanes cycle through three lines, and others where the lines run in descending order against the lane numbers. It also includes a pattern whose addresses wrap past the top of the address space. Stalls of the downstream port are mixed into these patterns, so the hold rule is checked in the middle of a batch and not only on its first request.

// File: rtl/coal_pkg.sv
package coal_pkg;
    localparam int COAL_LANES      = 32;
    localparam int COAL_AW         = 32;
    localparam int COAL_LINE_BYTES = 128;
endpackage

// File: rtl/coal_first_set.sv
module coal_first_set #(
    parameter int N  = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/coal_line_match.sv
module coal_line_match #(
    parameter int LANES = 32,
    parameter int LW    = 25,
    parameter int IW    = 5
) (
    input  logic [LANES*LW-1:0] lines,
    input  logic [LANES-1:0]    pending,
    input  logic [IW-1:0]       leader,
    output logic [LW-1:0]       line,
    output logic [LANES-1:0]    mask
);
    assign line = lines[LW*leader +: LW];

    for (genvar i = 0; i < LANES; i++) begin : g_cmp
        assign mask[i] = pending[i] && (lines[i*LW +: LW] == line);
    end
endmodule

// File: rtl/lane_coalescer.sv
module lane_coalescer
    import coal_pkg::*;
#(
    parameter int LANES      = COAL_LANES,
    parameter int AW         = COAL_AW,
    parameter int LINE_BYTES = COAL_LINE_BYTES,
    localparam int OFS = $clog2(LINE_BYTES),
    localparam int LW  = AW - OFS,
    localparam int IW  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CW  = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                batch_valid,
    output logic                batch_ready,
    input  logic [LANES-1:0]    lane_active,
    input  logic [LANES*AW-1:0] lane_addr,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [AW-1:0]       req_line,
    output logic [LANES-1:0]    req_mask,
    output logic                done,
    output logic [CW-1:0]       done_count
);
    typedef struct packed {
        logic [LANES-1:0]    pending;
        logic [LANES*LW-1:0] lines;
        logic [CW-1:0]       cnt;
        logic                done;
        logic [CW-1:0]       done_cnt;
    } state_t;

    state_t state_d, state_q;

    logic [LANES*LW-1:0]  lines_in;
    logic [LANES*OFS-1:0] lane_ofs_unused;
    logic                 leader_found;
    logic [IW-1:0]        leader_idx;
    logic [LW-1:0]        match_line;
    logic [LANES-1:0]     match_mask;

    // Only the line part of each address is kept; the byte offset inside the line is dropped
    for (genvar i = 0; i < LANES; i++) begin : g_split
        assign lines_in[i*LW +: LW]          = lane_addr[i*AW+OFS +: LW];
        assign lane_ofs_unused[i*OFS +: OFS] = lane_addr[i*AW +: OFS];
    end

    coal_first_set #(.N(LANES)) u_first (
        .vec   (state_q.pending),
        .found (leader_found),
        .idx   (leader_idx)
    );

    coal_line_match #(.LANES(LANES), .LW(LW), .IW(IW)) u_match (
        .lines   (state_q.lines),
        .pending (state_q.pending),
        .leader  (leader_idx),
        .line    (match_line),
        .mask    (match_mask)
    );

    assign batch_ready = ~|state_q.pending;
    assign req_valid   = leader_found;
    assign req_line    = {match_line, {OFS{1'b0}}};
    assign req_mask    = match_mask;
    assign done        = state_q.done;
    assign done_count  = state_q.done_cnt;

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (batch_valid && batch_ready) begin
            state_d.pending = lane_active;
            state_d.lines   = lines_in;
            state_d.cnt     = '0;
            if (lane_active == '0) begin
                state_d.done     = 1'b1;
                state_d.done_cnt = '0;
            end
        end else if (req_valid && req_ready) begin
            state_d.pending = state_q.pending & ~match_mask;
            state_d.cnt     = state_q.cnt + CW'(1);
            if (state_d.pending == '0) begin
                state_d.done     = 1'b1;
                state_d.done_cnt = state_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_line) && $stable(req_mask)); // R8
    AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_mask != '0) && ((req_mask & ~state_q.pending) == '0)); // R5
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        batch_ready |-> !req_valid); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> batch_ready); // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_count <= CW'(LANES)); // R3
    AST_SERVED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> (state_q.pending & $past(req_mask)) == '0); // R4
endmodule

// File: tb/lane_coalescer_bench.sv
module lane_coalescer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int L = 32;

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] base;
        logic [7:0]  stride;
        logic [31:0] active;
        logic [5:0]  exp_cnt;
        logic        stall;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h0000_1000, 8'd4,   32'hFFFF_FFFF, 6'd1,  1'b0},
        '{2'd0, 32'h0000_2000, 8'd128, 32'hFFFF_FFFF, 6'd32, 1'b0},
        '{2'd0, 32'h0000_0040, 8'd4,   32'hFFFF_FFFF, 6'd2,  1'b1},
        '{2'd0, 32'h0000_5004, 8'd0,   32'hFFFF_FFFF, 6'd1,  1'b1},
        '{2'd0, 32'h0000_3000, 8'd8,   32'hFFFF_FFFF, 6'd2,  1'b0},
        '{2'd0, 32'h0000_8000, 8'd128, 32'h0000_FFFF, 6'd16, 1'b1},
        '{2'd0, 32'h0000_9000, 8'd255, 32'hAAAA_AAAA, 6'd16, 1'b0},
        '{2'd1, 32'h0000_A000, 8'd3,   32'hFFFF_FFFF, 6'd3,  1'b1},
        '{2'd2, 32'h0000_C000, 8'd8,   32'hFFFF_FFFF, 6'd4,  1'b1},
        '{2'd0, 32'hFFFF_FFF8, 8'd4,   32'h0000_000F, 6'd2,  1'b0},
        '{2'd0, 32'h0000_0000, 8'd64,  32'h8000_0001, 6'd2,  1'b1},
        '{2'd0, 32'h0000_0000, 8'd4,   32'h0000_0000, 6'd0,  1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          batch_valid = 1'b0;
    logic          batch_ready;
    logic [L-1:0]  lane_active = '0;
    logic [L*32-1:0] lane_addr;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [31:0]   req_line;
    logic [L-1:0]  req_mask;
    logic          done;
    logic [5:0]    done_count;
    logic [31:0]   addr_arr [L];

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < L; i++) lane_addr[i*32 +: 32] = addr_arr[i];
    end

    lane_coalescer u_lane_coalescer (
        .clk(clk), .rst_n(rst_n), .batch_valid(batch_valid), .batch_ready(batch_ready),
        .lane_active(lane_active), .lane_addr(lane_addr), .req_valid(req_valid),
        .req_ready(req_ready), .req_line(req_line), .req_mask(req_mask),
        .done(done), .done_count(done_count)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input vec_t v);
        for (int i = 0; i < L; i++) begin
            case (v.mode)
                2'd1:    addr_arr[i] = v.base + 32'((i % int'(v.stride)) * 128 + i * 4);
                2'd2:    addr_arr[i] = v.base + 32'(((L - 1 - i) / int'(v.stride)) * 128 + (i % 8) * 4);
                default: addr_arr[i] = v.base + 32'(i * int'(v.stride));
            endcase
        end
    endtask

    // hold_other keeps offering a different batch while busy (R7: must be ignored)
    task automatic run_batch(input vec_t v, input bit hold_other);
        logic [L-1:0]  pend;
        logic [31:0]   exp_addr [L];
        int            n;
        @(negedge clk);
        fill(v);
        for (int i = 0; i < L; i++) exp_addr[i] = addr_arr[i];
        lane_active = v.active;
        batch_valid = 1'b1;
        chk(batch_ready === 1'b1, "R7", "ready before batch", 64'(batch_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        if (hold_other) begin
            lane_active = 32'hFFFF_FFFF;
            for (int i = 0; i < L; i++) addr_arr[i] = 32'h7777_0000 + 32'(i * 128);
        end else begin
            batch_valid = 1'b0;
        end
        pend = v.active;
        n = 0;
        if (v.active == '0) begin
            chk(done === 1'b1 && done_count === 6'd0 && req_valid === 1'b0, "R6",
                "empty batch done", {done, req_valid, done_count}, {1'b1, 1'b0, 6'd0});
        end else begin
            chk(batch_ready === 1'b0, "R7", "ready low while busy", 64'(batch_ready), 64'd0);
            for (int guard = 0; guard < 64 && pend != '0; guard++) begin
                int ld;
                logic [31:0] eline;
                logic [L-1:0] emask;
                ld = 0;
                for (int i = L - 1; i >= 0; i--) if (pend[i]) ld = i;
                eline = exp_addr[ld] & 32'hFFFF_FF80;
                emask = '0;
                for (int i = 0; i < L; i++)
                    if (pend[i] && ((exp_addr[i] & 32'hFFFF_FF80) == eline)) emask[i] = 1'b1;
                if (v.stall) begin
                    req_ready = 1'b0;
                    @(posedge clk);
                    @(negedge clk);
                    chk(req_valid === 1'b1 && req_line === eline && req_mask === emask, "R8",
                        "held under stall", {req_line, req_mask}, {eline, emask});
                end
                chk(req_valid === 1'b1 && req_line === eline, "R1", "line address",
                    64'(req_line), 64'(eline));
                chk(req_mask === emask, "R4", "mask and order", 64'(req_mask), 64'(emask));
                chk((req_mask & ~v.active) == '0, "R5", "inactive lane in mask",
                    64'(req_mask & ~v.active), 64'd0);
                req_ready = 1'b1;
                @(posedge clk);
                @(negedge clk);
                req_ready = 1'b0;
                pend = pend & ~emask;
                n = n + 1;
                if (pend != '0)
                    chk(done === 1'b0, "R9", "no early done", 64'(done), 64'd0);
            end
            chk(done === 1'b1 && done_count === 6'(n), "R9", "done count",
                64'(done_count), 64'(n));
            chk(n == int'(v.exp_cnt), (v.exp_cnt == 6'd1) ? "R2" : "R3", "request total",
                64'(n), 64'(v.exp_cnt));
            chk(req_valid === 1'b0, "R5", "no extra request", 64'(req_valid), 64'd0);
        end
        batch_valid = 1'b0;
        chk(batch_ready === 1'b1, "R7", "ready after batch", 64'(batch_ready), 64'd1);
        @(negedge clk);
        chk(done === 1'b0, "R9", "done single pulse", 64'(done), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < L; i++) addr_arr[i] = '0;
        repeat (3) @(negedge clk);
        chk(batch_ready === 1'b1 && req_valid === 1'b0, "R7", "reset state",
            {batch_ready, req_valid}, {1'b1, 1'b0});
        chk(done === 1'b0, "R9", "reset done", 64'(done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(batch_ready === 1'b1 && req_valid === 1'b0 && done === 1'b0, "R7",
            "after reset", {batch_ready, req_valid, done}, {1'b1, 1'b0, 1'b0});

        for (int k = 0; k < NV; k++) run_batch(VECS[k], 1'b0);

        // Directed: a different batch offered while busy must not disturb the current one
        run_batch(VECS[7], 1'b1);
        // Directed: two empty batches in a row, then a full coalesced batch
        run_batch(VECS[11], 1'b0);
        run_batch(VECS[11], 1'b0);
        run_batch(VECS[0], 1'b0);
        // Directed: reset in the middle of a batch clears pending work
        @(negedge clk);
        fill(VECS[1]);
        lane_active = 32'hFFFF_FFFF;
        batch_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        batch_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_valid === 1'b0 && batch_ready === 1'b1, "R7", "reset mid batch",
            {req_valid, batch_ready}, {1'b0, 1'b1});
        rst_n = 1'b1;
        run_batch(VECS[8], 1'b0);
        summary();
    end
endmodule